// File: doc/BRIEF.md
# Latched Overcurrent Channel Controller

This block supervises three independent low-side switch channels. Each channel takes an active-high command, a digital overcurrent flag from an external current sense, and drives a gate-enable output. While a supervisor-level output enable is active and the channel carries no latched fault, the gate follows the command with one clock of latency.

After every off-to-on transition of a gate, the channel opens a blanking window of a programmable number of ticks. During that window the overcurrent flag is ignored, so inrush and capacitor discharge spikes do not trip the channel. Once the window has run out, an asserted overcurrent flag turns the gate off and latches a per-channel fault. The fault can only be cleared by taking that channel's command low. The next rising command then switches the channel on again with a fresh blanking window. A tick prescaler sets the blanking resolution in clock cycles.

A fault on one channel never affects the other channels. A low global enable forces every gate off. That enable stands for sleep, overtemperature, regulator undervoltage or a watchdog alarm, all decided elsewhere.

Top module: `ocp_latch_ctrl`

## Requirements
- R1: While reset is asserted, and after its release until a command is applied, every gate output and every fault flag reads 0. Reset acts asynchronously.
- R2: With the global enable high and no latched fault, a channel's gate output becomes 1 on the clock edge after its command reads 1, and 0 on the clock edge after its command reads 0.
- R3: When the global enable reads 0, every gate goes to 0 on the next edge and stays 0. Latched fault flags keep their value. When the enable returns high, channels whose command is high switch on again.
- R4: An overcurrent flag seen on a channel that is fully on turns that channel's gate off and sets its fault flag on the next edge. The gates and fault flags of the other channels are unchanged.
- R5: While a channel's fault flag is 1 and its command stays high, the gate stays 0 and the flag stays 1, whether or not the overcurrent flag persists.
- R6: A latched fault clears on the edge after that channel's command reads 0. The channel then turns on again on the edge after its command reads 1.
- R7: After each off-to-on gate transition, the channel loads a counter with blank_ticks_i. The overcurrent flag is ignored on the following blank_ticks_i ticks. The window restarts on every new turn-on.
- R8: An overcurrent flag still asserted in the cycle the blanking counter has reached zero trips the channel on that edge. With blank_ticks_i = N and one-cycle ticks, the gate is high for exactly N+1 cycles before the trip.
- R9: With blank_ticks_i = 0, the overcurrent flag is already acted on at the first edge after turn-on.
- R10: If the overcurrent condition is still present when the command is reapplied, the channel turns on, blanks, and trips again on each reapplication.
- R11: Removing the command, or dropping the global enable, in the same cycle as an overcurrent flag turns the gate off without setting the fault flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| out_en_i | input | 1 | Global output enable from the supervisor; 0 forces all gates off |
| blank_ticks_i | input | BLANK_W (8) | Blanking length in prescaler ticks |
| cmd_i | input | NCH (3) | Per-channel active-high on command; bit n is channel n |
| oc_i | input | NCH (3) | Per-channel overcurrent flag; bit n is channel n |
| gate_o | output | NCH (3) | Per-channel gate enable |
| fault_o | output | NCH (3) | Per-channel latched overcurrent fault |

## Verification
Every cycle, the embedded properties check a set of per-channel rules. A disabled channel is off one edge later. A latched fault holds while its command stays high and clears once the command is low. No trip occurs while the blanking counter is nonzero. An overcurrent on a fully-on or just-expired channel trips it. The exact blanking length in cycles, the isolation between channels, the restart of the window on a second turn-on and the repeated trip against a persistent short are sequence properties, so only the bench's scenarios show them. The same holds for the priority of disable over trip and for asynchronous reset in the middle of a run.

// File: rtl/ocp_latch_pkg.sv
package ocp_latch_pkg;

  typedef enum logic [1:0] {
    CH_OFF   = 2'd0,
    CH_BLANK = 2'd1,
    CH_ON    = 2'd2,
    CH_TRIP  = 2'd3
  } ch_state_t;

endpackage

// File: rtl/ocp_rst_sync.sv
module ocp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/ocp_tick_gen.sv
module ocp_tick_gen #(
  parameter int TICK_DIV = 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);

  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (cnt_q == LAST) cnt_d = '0;
    else               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick_o = (cnt_q == LAST);

  AST_TICK_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R7

endmodule

// File: rtl/ocp_channel.sv
module ocp_channel
  import ocp_latch_pkg::*;
#(
  parameter int BLANK_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_i,
  input  logic               out_en_i,
  input  logic [BLANK_W-1:0] blank_ticks_i,
  input  logic               cmd_i,
  input  logic               oc_i,
  output logic               gate_o,
  output logic               fault_o
);

  ch_state_t          st_q, st_d;
  logic [BLANK_W-1:0] cnt_q, cnt_d;
  logic               cnt_en;
  logic               run_req;
  logic               blank_done;

  assign run_req    = out_en_i && cmd_i;
  assign blank_done = (cnt_q == '0);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    unique case (st_q)
      CH_OFF: begin
        if (run_req) begin
          st_d   = CH_BLANK;
          cnt_d  = blank_ticks_i;
          cnt_en = 1'b1;
        end
      end
      CH_BLANK: begin
        if (!run_req) begin
          st_d = CH_OFF;
        end else if (blank_done) begin
          st_d = oc_i ? CH_TRIP : CH_ON;
        end else if (tick_i) begin
          cnt_d  = cnt_q - 1'b1;
          cnt_en = 1'b1;
        end
      end
      CH_ON: begin
        if (!run_req)  st_d = CH_OFF;
        else if (oc_i) st_d = CH_TRIP;
      end
      CH_TRIP: begin
        if (!cmd_i) st_d = CH_OFF;
      end
      default: st_d = CH_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= CH_OFF;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign gate_o  = (st_q == CH_BLANK) || (st_q == CH_ON);
  assign fault_o = (st_q == CH_TRIP);

  AST_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_en_i && cmd_i) |=> !gate_o); // R3

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_o && cmd_i) |=> (fault_o && !gate_o)); // R5

  AST_FAULT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_o && !cmd_i) |=> !fault_o); // R6

  AST_BLANK_NO_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CH_BLANK && !blank_done) |=> !fault_o); // R7

  AST_TRIP_WHEN_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CH_ON && out_en_i && cmd_i && oc_i) |=> (fault_o && !gate_o)); // R4

  AST_TRIP_AT_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CH_BLANK && blank_done && out_en_i && cmd_i && oc_i) |=> fault_o); // R8

endmodule

// File: rtl/ocp_latch_ctrl.sv
module ocp_latch_ctrl
  import ocp_latch_pkg::*;
#(
  parameter int NCH      = 3,
  parameter int BLANK_W  = 8,
  parameter int TICK_DIV = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               out_en_i,
  input  logic [BLANK_W-1:0] blank_ticks_i,
  input  logic [NCH-1:0]     cmd_i,
  input  logic [NCH-1:0]     oc_i,
  output logic [NCH-1:0]     gate_o,
  output logic [NCH-1:0]     fault_o
);

  logic rst_int_n;
  logic tick;

  ocp_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  ocp_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .tick_o (tick)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    ocp_channel #(.BLANK_W(BLANK_W)) u_ch (
      .clk           (clk),
      .rst_n         (rst_int_n),
      .tick_i        (tick),
      .out_en_i      (out_en_i),
      .blank_ticks_i (blank_ticks_i),
      .cmd_i         (cmd_i[ch]),
      .oc_i          (oc_i[ch]),
      .gate_o        (gate_o[ch]),
      .fault_o       (fault_o[ch])
    );
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (gate_o == '0 && fault_o == '0)); // R1

endmodule

// File: tb/ocp_latch_ctrl_tb_top.sv
module ocp_latch_ctrl_tb_top;

  localparam int NCH = 3;
  localparam int BW  = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          out_en;
  logic [BW-1:0] blank;
  logic [2:0]    cmd, oc;
  logic [2:0]    gate_o, fault_o;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  ocp_latch_ctrl #(.NCH(NCH), .BLANK_W(BW), .TICK_DIV(1)) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .out_en_i      (out_en),
    .blank_ticks_i (blank),
    .cmd_i         (cmd),
    .oc_i          (oc),
    .gate_o        (gate_o),
    .fault_o       (fault_o)
  );

  // {en, cmd[2:0], oc[2:0], exp_gate[2:0], exp_fault[2:0]}, blank = 2
  localparam int NV = 24;
  localparam logic [12:0] VEC [NV] = '{
    13'b1_000_000_000_000,
    13'b1_001_000_001_000,
    13'b1_001_001_001_000,
    13'b1_001_001_001_000,
    13'b1_001_001_000_001,
    13'b1_001_000_000_001,
    13'b1_011_000_010_001,
    13'b1_010_000_010_000,
    13'b1_011_000_011_000,
    13'b1_011_000_011_000,
    13'b1_011_000_011_000,
    13'b1_011_000_011_000,
    13'b1_011_010_001_010,
    13'b1_011_000_001_010,
    13'b1_001_000_001_000,
    13'b1_011_010_011_000,
    13'b1_011_010_011_000,
    13'b1_011_010_011_000,
    13'b1_011_010_001_010,
    13'b0_011_000_000_010,
    13'b0_011_000_000_010,
    13'b1_011_000_001_010,
    13'b1_111_000_101_010,
    13'b1_110_001_100_010
  };

  function automatic string row_req(input int r);
    case (r)
      2, 3:             return "R7";
      4:                return "R8";
      5, 13:            return "R5";
      6, 12:            return "R4";
      7, 8, 14:         return "R6";
      15, 16, 17, 18:   return "R10";
      19, 20, 21:       return "R3";
      default:          return "R2";
    endcase
  endfunction

  task automatic check(input logic [2:0] ge, input logic [2:0] fe, input string tag);
    tests++;
    if (gate_o !== ge || fault_o !== fe) begin
      fails++;
      $display("FAIL %s: gate=%b fault=%b, expected gate=%b fault=%b",
               tag, gate_o, fault_o, ge, fe);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #1000000;
    tests++;
    fails++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    rst_n  = 1'b0;
    out_en = 1'b0;
    blank  = 8'd2;
    cmd    = '0;
    oc     = '0;
    repeat (3) @(negedge clk);
    check(3'b000, 3'b000, "R1 during reset");
    rst_n = 1'b1;
    repeat (3) step();
    check(3'b000, 3'b000, "R1 after release");

    for (int i = 0; i < NV; i++) begin
      out_en = VEC[i][12];
      cmd    = VEC[i][11:9];
      oc     = VEC[i][8:6];
      step();
      check(VEC[i][5:3], VEC[i][2:0], $sformatf("%s row %0d", row_req(i), i));
    end

    // R1: asynchronous reset with a channel on and a fault latched
    #3 rst_n = 1'b0;
    #2 check(3'b000, 3'b000, "R1 async mid-run");
    cmd = '0; oc = '0; out_en = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) step();

    // R9: zero-length window, overcurrent acted on at first edge after turn-on
    blank = 8'd0;
    cmd = 3'b100;
    step();
    check(3'b100, 3'b000, "R9 turn-on");
    oc = 3'b100;
    step();
    check(3'b000, 3'b100, "R9 immediate trip");
    cmd = '0; oc = '0;
    step();
    check(3'b000, 3'b000, "R6 clear");

    // R7: window restarts on a second turn-on
    blank = 8'd3;
    cmd = 3'b001;
    repeat (4) step();
    check(3'b001, 3'b000, "R2 on after window");
    cmd = '0;
    step();
    check(3'b000, 3'b000, "R2 off");
    cmd = 3'b001; oc = 3'b001;
    step();
    check(3'b001, 3'b000, "R7 restart turn-on");
    for (int k = 0; k < 3; k++) begin
      step();
      check(3'b001, 3'b000, "R7 restarted window ignores sense");
    end
    step();
    check(3'b000, 3'b001, "R8 trip at expiry");
    cmd = '0; oc = '0;
    step();

    // R11: disable wins over a simultaneous overcurrent
    blank = 8'd0;
    cmd = 3'b001;
    step();
    step();
    check(3'b001, 3'b000, "R11 channel on");
    out_en = 1'b0; oc = 3'b001;
    step();
    check(3'b000, 3'b000, "R11 enable drop with oc");
    out_en = 1'b1; oc = '0;
    step();
    step();
    check(3'b001, 3'b000, "R3 resume");
    cmd = 3'b000; oc = 3'b001;
    step();
    check(3'b000, 3'b000, "R11 cmd drop with oc");

    finish_run();
  end

endmodule